// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets an external controller read and write a bank of 8-bit configuration registers over four wires. The wires are an active-low select, a serial clock, a data input and a data output. Every access is a 16-bit word, sent most significant bit first. The word carries a direction bit, a reserved bit, a 6-bit register address and 8 data bits. The controller may keep the select low and send any number of words back to back. If a window ends partway through a word, the unfinished word is thrown away.

On a read word, the addressed register comes out on the data output, most significant bit first. Each bit changes on a falling serial clock edge, so the controller can latch it on the next rising edge. An output-enable pin marks when the block drives the data output; at all other times the pin is meant to float.

All registers return to their defaults in two cases: a high level on the hardware reset input, or a write of 1 to the self-clearing software reset bit. The serial inputs are synchronized into a system clock that runs at least four times faster than the serial clock. The whole register bank is brought out in parallel for the logic it configures.

Top module: `regspi_slave`

## Requirements
- R1: While the reset input is high, and after it is released, every register holds its default: address 1Fh holds FFh, address 30h holds 40h, and every other address holds 00h.
- R2: A word is 16 bits, sent first bit first. Word bit 15 is the direction (0 = write), bit 14 must be 0, bits 13..8 are the register address and bits 7..0 are the data. A write takes effect on the 16th rising serial clock edge of the word.
- R3: While the select stays low, words follow each other with no gap. Each completed write word is committed, and a read word placed after write words in the same window returns the newly written value.
- R4: When the select rises, any bits left after the last complete 16-bit word are discarded. No register changes, and the next window starts a fresh word.
- R5: On a read word (bit 15 = 1), the 8 bits of the addressed register appear on `sdo`, most significant bit first. Each bit changes after a falling serial clock edge and is valid at rising edges 9 to 16 of the word.
- R6: `sdo_en` is low while the select is high, during the whole of every write word, and during the first 8 bits of a read word. It is high during the data phase of a read word.
- R7: A write whose bit 14 is 1, or whose address is not implemented, changes nothing. A read of such a word returns 00h. The implemented addresses are 06h-08h, 0Bh-13h, 1Fh, 26h, 27h, 2Bh-2Dh, 30h and 36h-38h.
- R8: Writing a value with bit 0 set to address 08h restores every register to its R1 default. After that, address 08h reads back 00h, so bit 0 has cleared itself.
- R9: Serial clock edges and data while the select is high have no effect.
- R10: `regs_o[8*a+7 : 8*a]` carries the current contents of register address a, and reads 00h for addresses that are not implemented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Hardware reset, active high, loads defaults |
| sel_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in, sampled on rising `sck` |
| sdo | output | 1 | Serial data out, changes after falling `sck` |
| sdo_en | output | 1 | Drive enable for `sdo` (low = high impedance) |
| regs_o | output | 512 | Parallel image of all 64 register addresses |

## Verification
The bench builds the block with its default parameters: a 6-bit address, 8-bit data, a two-stage synchronizer and the standard set of implemented addresses. It drives a serial clock that is twelve times slower than the system clock. These settings put the unimplemented addresses 01h and 3Fh, the top of the address space and both non-zero defaults within reach of ordinary transactions. They also allow long streamed windows, with several words each, to be checked against the parallel register image.

// File: rtl/regspi_pkg.sv
package regspi_pkg;

  localparam int REG_BITS = 8;

  // Reset value of a register address
  function automatic logic [REG_BITS-1:0] reg_default(input int idx);
    case (idx)
      8'h1F:   return 8'hFF;
      8'h30:   return 8'h40;
      default: return 8'h00;
    endcase
  endfunction

  // Number of bits in one serial word
  function automatic int word_bits(input int addr_w, input int data_w);
    return 2 + addr_w + data_w;
  endfunction

endpackage

// File: rtl/regspi_sync.sv
module regspi_sync #(
  parameter int            W       = 3,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or posedge rst) begin
      if (rst)         st[g] <= RST_VAL;
      else if (g == 0) st[g] <= d;
      else             st[g] <= st[(g == 0) ? 0 : g-1];
    end
  end

  assign q = st[STAGES-1];

endmodule

// File: rtl/regspi_frame.sv
module regspi_frame
  import regspi_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n_s,
  input  logic              sck_s,
  input  logic              sdi_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_block,
  output logic              wr_evt,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              wr_block,
  output logic [DATA_W-1:0] wr_data,
  output logic              sdo,
  output logic              sdo_en
);

  localparam int WORD_W = word_bits(ADDR_W, DATA_W);
  localparam int HDR_W  = 2 + ADDR_W;
  localparam int CNT_W  = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] HDR_END  = CNT_W'(HDR_W - 1);

  logic              sck_d;
  logic [WORD_W-2:0] sh;
  logic [WORD_W-1:0] next_sh;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W:0]   hdr;
  logic              rd_pend;
  logic              sdo_en_q;
  logic [DATA_W-1:0] obuf;

  // Named events for the checks
  logic active, rise_evt, fall_evt, hdr_done;

  assign active   = ~sel_n_s;
  assign rise_evt = active & sck_s & ~sck_d;
  assign fall_evt = active & ~sck_s & sck_d;
  assign next_sh  = {sh, sdi_s};
  assign hdr_done = rise_evt & (cnt == HDR_END);

  assign wr_evt   = rise_evt & (cnt == LAST_BIT) & ~next_sh[WORD_W-1];
  assign wr_block = next_sh[DATA_W+ADDR_W];
  assign wr_addr  = next_sh[DATA_W +: ADDR_W];
  assign wr_data  = next_sh[DATA_W-1:0];

  assign rd_addr  = hdr[ADDR_W-1:0];
  assign rd_block = hdr[ADDR_W];
  assign sdo      = obuf[DATA_W-1] & sdo_en_q;
  assign sdo_en   = sdo_en_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sck_d    <= 1'b0;
      sh       <= '0;
      cnt      <= '0;
      hdr      <= '0;
      rd_pend  <= 1'b0;
      sdo_en_q <= 1'b0;
      obuf     <= '0;
    end else begin
      sck_d <= sck_s;
      if (!active) begin
        cnt      <= '0;
        rd_pend  <= 1'b0;
        sdo_en_q <= 1'b0;
        obuf     <= '0;
      end else begin
        if (rise_evt) begin
          sh  <= next_sh[WORD_W-2:0];
          cnt <= (cnt == LAST_BIT) ? '0 : cnt + 1'b1;
          if (hdr_done) begin
            hdr     <= next_sh[ADDR_W:0];
            rd_pend <= next_sh[HDR_W-1];
          end
        end
        if (fall_evt) begin
          if (rd_pend) begin
            obuf     <= rd_data;
            sdo_en_q <= 1'b1;
            rd_pend  <= 1'b0;
          end else if (sdo_en_q && cnt == '0) begin
            sdo_en_q <= 1'b0;
          end else if (sdo_en_q) begin
            obuf <= obuf << 1;
          end
        end
      end
    end
  end

  // R6: deselect releases the output
  assert_release_on_deselect_R6: assert property (@(posedge clk) disable iff (rst)
    !active |=> !sdo_en_q);

  // R6: no drive while a write word completes
  assert_quiet_on_write_R6: assert property (@(posedge clk) disable iff (rst)
    wr_evt |-> !sdo_en_q);

  // R5: driven data moves only after a falling serial edge
  assert_sdo_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
    (sdo_en_q && $past(sdo_en_q) && !$stable(sdo)) |-> $past(fall_evt));

endmodule

// File: rtl/regspi_regfile.sv
module regspi_regfile
  import regspi_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter logic [(1<<ADDR_W)-1:0] IMPL_MASK = '1,
  parameter int SWRST_ADDR = 8,
  parameter int SWRST_BIT  = 0
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_evt,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic                             wr_block,
  input  logic [DATA_W-1:0]                wr_data,
  input  logic [ADDR_W-1:0]                rd_addr,
  input  logic                             rd_block,
  output logic [DATA_W-1:0]                rd_data,
  output logic [(1<<ADDR_W)*DATA_W-1:0]    regs_o
);

  localparam int NREG = 1 << ADDR_W;

  logic [DATA_W-1:0] regs [NREG];
  logic wr_ok, swrst;

  assign wr_ok = wr_evt & ~wr_block;
  assign swrst = wr_ok & (wr_addr == ADDR_W'(SWRST_ADDR)) & wr_data[SWRST_BIT];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (IMPL_MASK[i]) begin : g_impl
      always_ff @(posedge clk or posedge rst) begin
        if (rst)                                     regs[i] <= DATA_W'(reg_default(i));
        else if (swrst)                              regs[i] <= DATA_W'(reg_default(i));
        else if (wr_ok && wr_addr == ADDR_W'(i))     regs[i] <= wr_data;
      end
    end else begin : g_none
      assign regs[i] = '0;
    end
    assign regs_o[i*DATA_W +: DATA_W] = regs[i];
  end

  assign rd_data = rd_block ? '0 : regs[rd_addr];

  // R8: software reset restores defaults and clears its own bit
  assert_swrst_defaults_R8: assert property (@(posedge clk) disable iff (rst)
    swrst |=> (regs[SWRST_ADDR] == '0) && (regs[8'h1F] == DATA_W'(8'hFF)));

  // R2: an accepted write lands in its register
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && !swrst && IMPL_MASK[wr_addr]) |=> regs[$past(wr_addr)] == $past(wr_data));

  // R7: blocked writes leave the target alone
  assert_blocked_write_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_evt && wr_block) |=> $stable(regs[$past(wr_addr)]));

endmodule

// File: rtl/regspi_slave.sv
module regspi_slave
  import regspi_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [(1<<ADDR_W)-1:0] IMPL_MASK = 64'h01C1_38C0_800F_F9C0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          sel_n,
  input  logic                          sck,
  input  logic                          sdi,
  output logic                          sdo,
  output logic                          sdo_en,
  output logic [(1<<ADDR_W)*DATA_W-1:0] regs_o
);

  logic [2:0]        pins_s;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              rd_block, wr_block, wr_evt;

  regspi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk (clk), .rst (rst),
    .d   ({sck, sdi, sel_n}),
    .q   (pins_s)
  );

  regspi_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk      (clk),        .rst      (rst),
    .sel_n_s  (pins_s[0]),  .sck_s    (pins_s[2]),  .sdi_s (pins_s[1]),
    .rd_data  (rd_data),    .rd_addr  (rd_addr),    .rd_block (rd_block),
    .wr_evt   (wr_evt),     .wr_addr  (wr_addr),    .wr_block (wr_block),
    .wr_data  (wr_data),    .sdo      (sdo),        .sdo_en   (sdo_en)
  );

  regspi_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IMPL_MASK(IMPL_MASK)) u_regs (
    .clk      (clk),      .rst      (rst),
    .wr_evt   (wr_evt),   .wr_addr  (wr_addr),  .wr_block (wr_block),
    .wr_data  (wr_data),  .rd_addr  (rd_addr),  .rd_block (rd_block),
    .rd_data  (rd_data),  .regs_o   (regs_o)
  );

endmodule

// File: tb/tb_regspi_slave.sv
module tb_regspi_slave;

  localparam int H = 6;   // system clocks per serial half period

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sel_n = 1'b1;
  logic         sck = 1'b0;
  logic         sdi = 1'b0;
  logic         sdo, sdo_en;
  logic [511:0] regs_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  regspi_slave dut (
    .clk (clk), .rst (rst), .sel_n (sel_n), .sck (sck), .sdi (sdi),
    .sdo (sdo), .sdo_en (sdo_en), .regs_o (regs_o)
  );

  // addr, write data, expected readback
  localparam logic [23:0] VEC [8] = '{
    24'h06_5A_5A, 24'h0F_C3_C3, 24'h38_FF_FF, 24'h01_77_00,
    24'h1F_12_12, 24'h30_00_00, 24'h3F_AA_00, 24'h08_F6_F6
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic sel_low();
    @(negedge clk); sel_n = 1'b0; wait_clk(H);
  endtask

  task automatic sel_high();
    wait_clk(H); sel_n = 1'b1; wait_clk(2*H);
  endtask

  // Shift nb bits of w; capture sdo before rises 9..16
  task automatic xfer(input logic [15:0] w, input int nb,
                      output logic [7:0] rd, output logic en_any, output logic en_data);
    rd = '0; en_any = 1'b0; en_data = 1'b1;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk); sdi = w[15-i];
      wait_clk(H);
      if (sdo_en) en_any = 1'b1;
      if (i >= 8) begin
        rd[15-i] = sdo;
        if (!sdo_en) en_data = 1'b0;
      end
      sck = 1'b1; wait_clk(H);
      sck = 1'b0;
    end
  endtask

  task automatic wr(input logic [7:0] abyte, input logic [7:0] d, input string tag);
    logic [7:0] r; logic ea, ed;
    sel_low(); xfer({abyte, d}, 16, r, ea, ed); sel_high();
    check({tag, " R6 no drive on write"}, 32'(ea), 0);
  endtask

  task automatic rd(input logic [7:0] abyte, output logic [7:0] d, output logic ed);
    logic ea;
    sel_low(); xfer({abyte | 8'h80, 8'h00}, 16, d, ea, ed); sel_high();
  endtask

  initial begin
    logic [7:0] r; logic ea, ed;
    wait_clk(5);
    check("R1 rst regs_o 1F", 32'(regs_o[8*8'h1F +: 8]), 32'hFF);
    rst = 1'b0;
    wait_clk(5);
    check("R6 idle sdo_en", 32'(sdo_en), 0);

    // R1 defaults via the serial port
    rd(8'h1F, r, ed); check("R1 read 1F", 32'(r), 32'hFF);
    check("R6 drive during read data", 32'(ed), 1);
    rd(8'h30, r, ed); check("R1 read 30", 32'(r), 32'h40);
    rd(8'h06, r, ed); check("R1 read 06", 32'(r), 32'h00);
    check("R10 regs_o 30", 32'(regs_o[8*8'h30 +: 8]), 32'h40);

    // R2 R5 R7 R10 table
    for (int v = 0; v < 8; v++) begin
      wr(VEC[v][23:16], VEC[v][15:8], "R2 table write");
      rd(VEC[v][23:16], r, ed);
      check($sformatf("R5 table read %0h", VEC[v][23:16]), 32'(r), 32'(VEC[v][7:0]));
      check($sformatf("R10 table image %0h", VEC[v][23:16]),
            32'(regs_o[8*VEC[v][21:16] +: 8]), 32'(VEC[v][7:0]));
    end

    // R3 streamed words
    sel_low();
    xfer({8'h10, 8'h11}, 16, r, ea, ed);
    xfer({8'h11, 8'h22}, 16, r, ea, ed);
    check("R6 streamed writes quiet", 32'(ea), 0);
    xfer({8'h90, 8'h00}, 16, r, ea, ed);
    check("R3 streamed read 10", 32'(r), 32'h11);
    sel_high();
    check("R3 image 11", 32'(regs_o[8*8'h11 +: 8]), 32'h22);

    // R4 trailing bits discarded
    wr(8'h12, 8'h33, "R4 setup");
    sel_low();
    xfer({8'h13, 8'h44}, 16, r, ea, ed);
    xfer({8'h12, 8'h99}, 10, r, ea, ed);
    sel_high();
    check("R4 partial left 12", 32'(regs_o[8*8'h12 +: 8]), 32'h33);
    check("R4 full word 13", 32'(regs_o[8*8'h13 +: 8]), 32'h44);
    rd(8'h12, r, ed); check("R4 fresh word after window", 32'(r), 32'h33);

    // R7 reserved bit set
    wr(8'h46, 8'h55, "R7");
    rd(8'h06, r, ed); check("R7 blocked write kept 06", 32'(r), 32'h5A);
    rd(8'h46, r, ed); check("R7 blocked read zero", 32'(r), 32'h00);

    // R9 activity while deselected
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); sdi = 1'b1; wait_clk(H); sck = 1'b1; wait_clk(H); sck = 1'b0;
    end
    check("R9 no drive while deselected", 32'(sdo_en), 0);
    wr(8'h07, 8'h03, "R9");
    rd(8'h07, r, ed); check("R9 word aligned after idle clocks", 32'(r), 32'h03);

    // R8 software reset
    wr(8'h08, 8'h09, "R8");
    rd(8'h08, r, ed); check("R8 reset bit cleared", 32'(r), 32'h00);
    rd(8'h06, r, ed); check("R8 06 default", 32'(r), 32'h00);
    check("R8 1F default", 32'(regs_o[8*8'h1F +: 8]), 32'hFF);
    check("R8 30 default", 32'(regs_o[8*8'h30 +: 8]), 32'h40);

    // R1 hardware reset mid-run
    wr(8'h2C, 8'h01, "R1");
    check("R1 before hw reset", 32'(regs_o[8*8'h2C +: 8]), 32'h01);
    @(negedge clk); rst = 1'b1; wait_clk(3); rst = 1'b0; wait_clk(3);
    check("R1 hw reset 2C", 32'(regs_o[8*8'h2C +: 8]), 32'h00);
    check("R1 hw reset 1F", 32'(regs_o[8*8'h1F +: 8]), 32'hFF);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule